// File: doc/BRIEF.md
# Calendar Timekeeper with Shadow Buffers

This block keeps a binary calendar (year, month, day, hour, minute, second) in internal counters. The counters advance by one second on each cycle where the one-second tick input is high. A separate bank of six host-visible buffer registers normally mirrors the counters. The copy into the buffers happens on the same clock edge that advances the counters. The internal counter values and a one-cycle pulse marking each completed second are exported so that an alarm comparator can sample the fresh time.

The host controls the block through two level flags and one request pulse. The stop flag freezes timekeeping and the mirroring. The update-disable flag freezes only the mirroring, so a multi-field read stays coherent while the counters keep running. The load request copies all six buffers into the counters one cycle later and then clears itself. To set the time, the host writes buffers through a byte-wide write port selected by a 3-bit field code and then raises the load request. After reset the seconds buffer holds an invalid marker until the first tick overwrites it.

Top module: `cal_timekeeper`

## Requirements
- R1: After synchronous reset the counters read year 0, month 1, day 1, 00:00:00. The buffers read the same, except that the seconds buffer reads 0xFF. sec_pulse_o and load_pend_o are 0.
- R2: Seconds and minutes wrap from 59 to 0 and hours wrap from 23 to 0. Each wrap carries one step into the next larger field.
- R3: The day wraps to 1 after 28/29 (February), 30 (April, June, September, November) or 31 (all other months). A year is leap when its two low bits are zero. Month wraps from 12 to 1 and carries into the year, and the year wraps from 255 to 0.
- R4: While stop_i is 1, a tick changes no counter and no buffer, and produces no sec_pulse_o.
- R5: While upd_dis_i is 1, a tick advances the counters but leaves every buffer unchanged.
- R6: When a tick advances the counters and upd_dis_i is 0, all six buffers take the new counter values on the same clock edge.
- R7: A buffer write with buf_we_i=1 stores buf_wdata_i in the field selected by buf_sel_i. The codes are 0 second, 1 minute, 2 hour, 3 day, 4 month and 5 year, and codes 6 and 7 change nothing. In a cycle that also copies, the written field takes the written value.
- R8: A 1 on load_set_i makes load_pend_o 1 in the next cycle. At the end of that cycle the counters take the six buffer values and load_pend_o returns to 0, unless load_set_i is 1 again.
- R9: A tick arriving in the cycle where load_pend_o is 1 is discarded. No advance and no pulse follow it.
- R10: sec_pulse_o is 1 for exactly the one cycle after each advancing tick, while the new counter values are visible.
- R11: A field loaded with a value at or above its upper limit goes to its lowest value and carries on its next step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse, once per second |
| stop_i | input | 1 | Freeze timekeeping and mirroring |
| upd_dis_i | input | 1 | Freeze mirroring into the buffers only |
| load_set_i | input | 1 | Request loading the counters from the buffers |
| buf_we_i | input | 1 | Buffer write strobe |
| buf_sel_i | input | 3 | Buffer field code (0 sec .. 5 year) |
| buf_wdata_i | input | 8 | Buffer write data |
| buf_year_o | output | 8 | Year buffer |
| buf_month_o | output | 8 | Month buffer |
| buf_day_o | output | 8 | Day buffer |
| buf_hour_o | output | 8 | Hour buffer |
| buf_min_o | output | 8 | Minute buffer |
| buf_sec_o | output | 8 | Second buffer |
| cnt_year_o | output | 8 | Year counter |
| cnt_month_o | output | 8 | Month counter |
| cnt_day_o | output | 8 | Day counter |
| cnt_hour_o | output | 8 | Hour counter |
| cnt_min_o | output | 8 | Minute counter |
| cnt_sec_o | output | 8 | Second counter |
| sec_pulse_o | output | 1 | One-cycle mark after each advance |
| load_pend_o | output | 1 | Load executes at the end of this cycle |

## Verification
The assertions assume that tick_i is a single-cycle pulse and that the flags are plain levels sampled at the clock. They make no assumption about field values, because out-of-range loads are legal. The second-range check depends on that: the seconds counter can only come out of an advance within 0..59, whatever value it was loaded with. The bench changes tick_i, flags and write-port inputs only between edges. It keeps ticks isolated by a cycle so that every pulse window is observable. It loads deliberately invalid values only in the R11 case.

// File: rtl/cal_tk_pkg.sv
`timescale 1ns/1ps
package cal_tk_pkg;
  localparam int unsigned FW = 8;
  localparam int unsigned NF = 6;
  localparam int unsigned SW = 3;

  localparam int I_SEC  = 0;
  localparam int I_MIN  = 1;
  localparam int I_HOUR = 2;
  localparam int I_DAY  = 3;
  localparam int I_MON  = 4;
  localparam int I_YEAR = 5;

  typedef logic [FW-1:0] fld_t;
  typedef fld_t [NF-1:0] tvec_t;

  function automatic fld_t low_of(int idx);
    return (idx == I_DAY || idx == I_MON) ? fld_t'(1) : fld_t'(0);
  endfunction
endpackage

// File: rtl/cal_tk_dim.sv
`timescale 1ns/1ps
module cal_tk_dim
  import cal_tk_pkg::*;
#(
  parameter int unsigned LEAP_BITS = 2
) (
  input  fld_t                 mon_i,
  input  logic [LEAP_BITS-1:0] yr_lo_i,
  output fld_t                 dim_o
);
  logic leap;
  assign leap = (yr_lo_i == '0);

  always_comb begin
    case (mon_i)
      fld_t'(2):                                  dim_o = leap ? fld_t'(29) : fld_t'(28);
      fld_t'(4), fld_t'(6), fld_t'(9), fld_t'(11): dim_o = fld_t'(30);
      default:                                    dim_o = fld_t'(31);
    endcase
  end
endmodule

// File: rtl/cal_tk_step.sv
`timescale 1ns/1ps
module cal_tk_step
  import cal_tk_pkg::*;
#(
  parameter fld_t LO = '0
) (
  input  logic en_i,
  input  fld_t cur_i,
  input  fld_t hi_i,
  output fld_t nxt_o,
  output logic carry_o
);
  logic at_top;
  assign at_top  = (cur_i >= hi_i);
  assign carry_o = en_i && at_top;

  always_comb begin
    if (!en_i)      nxt_o = cur_i;
    else if (at_top) nxt_o = LO;
    else            nxt_o = cur_i + fld_t'(1);
  end
endmodule

// File: rtl/cal_tk_core.sv
`timescale 1ns/1ps
module cal_tk_core
  import cal_tk_pkg::*;
#(
  parameter int unsigned SEC_MAX   = 59,
  parameter int unsigned MIN_MAX   = 59,
  parameter int unsigned HOUR_MAX  = 23,
  parameter int unsigned MON_MAX   = 12,
  parameter int unsigned LEAP_BITS = 2
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  tick_i,
  input  logic  stop_i,
  input  logic  load_i,
  input  tvec_t src_i,
  output tvec_t cnt_o,
  output tvec_t nxt_o,
  output logic  adv_o,
  output logic  pulse_o
);
  localparam int unsigned NSTEP = NF - 1;

  tvec_t            cnt_q;
  tvec_t            nxt;
  logic [NF-1:0]    en;
  fld_t             hi [NSTEP];
  fld_t             dim;

  assign adv_o = tick_i && !stop_i && !load_i;
  assign en[0] = adv_o;

  cal_tk_dim #(.LEAP_BITS(LEAP_BITS)) u_dim (
    .mon_i   (cnt_q[I_MON]),
    .yr_lo_i (cnt_q[I_YEAR][LEAP_BITS-1:0]),
    .dim_o   (dim)
  );

  always_comb begin
    hi[I_SEC]  = fld_t'(SEC_MAX);
    hi[I_MIN]  = fld_t'(MIN_MAX);
    hi[I_HOUR] = fld_t'(HOUR_MAX);
    hi[I_DAY]  = dim;
    hi[I_MON]  = fld_t'(MON_MAX);
  end

  for (genvar g = 0; g < NSTEP; g++) begin : g_stage
    cal_tk_step #(.LO(low_of(g))) u_step (
      .en_i    (en[g]),
      .cur_i   (cnt_q[g]),
      .hi_i    (hi[g]),
      .nxt_o   (nxt[g]),
      .carry_o (en[g+1])
    );
  end

  assign nxt[I_YEAR] = en[I_YEAR] ? cnt_q[I_YEAR] + fld_t'(1) : cnt_q[I_YEAR];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NF; i++) cnt_q[i] <= low_of(i);
      pulse_o <= 1'b0;
    end else if (load_i) begin
      cnt_q   <= src_i;
      pulse_o <= 1'b0;
    end else begin
      cnt_q   <= nxt;
      pulse_o <= adv_o;
    end
  end

  assign cnt_o = cnt_q;
  assign nxt_o = nxt;
endmodule

// File: rtl/cal_tk_shadow.sv
`timescale 1ns/1ps
module cal_tk_shadow
  import cal_tk_pkg::*;
#(
  parameter fld_t SEC_POR = 8'hFF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          copy_i,
  input  tvec_t         src_i,
  input  logic          we_i,
  input  logic [SW-1:0] sel_i,
  input  fld_t          wdata_i,
  output tvec_t         buf_o
);
  tvec_t buf_q;

  for (genvar f = 0; f < NF; f++) begin : g_fld
    localparam fld_t POR = (f == I_SEC) ? SEC_POR : low_of(f);
    logic hit;
    assign hit = we_i && (sel_i == SW'(f));

    always_ff @(posedge clk) begin
      if (rst)         buf_q[f] <= POR;
      else if (hit)    buf_q[f] <= wdata_i;
      else if (copy_i) buf_q[f] <= src_i[f];
    end
  end

  assign buf_o = buf_q;
endmodule

// File: rtl/cal_timekeeper.sv
`timescale 1ns/1ps
module cal_timekeeper
  import cal_tk_pkg::*;
#(
  parameter int unsigned SEC_MAX   = 59,
  parameter int unsigned MIN_MAX   = 59,
  parameter int unsigned HOUR_MAX  = 23,
  parameter int unsigned MON_MAX   = 12,
  parameter int unsigned LEAP_BITS = 2,
  parameter int unsigned SEC_POR   = 255
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          stop_i,
  input  logic          upd_dis_i,
  input  logic          load_set_i,
  input  logic          buf_we_i,
  input  logic [SW-1:0] buf_sel_i,
  input  logic [FW-1:0] buf_wdata_i,
  output logic [FW-1:0] buf_year_o,
  output logic [FW-1:0] buf_month_o,
  output logic [FW-1:0] buf_day_o,
  output logic [FW-1:0] buf_hour_o,
  output logic [FW-1:0] buf_min_o,
  output logic [FW-1:0] buf_sec_o,
  output logic [FW-1:0] cnt_year_o,
  output logic [FW-1:0] cnt_month_o,
  output logic [FW-1:0] cnt_day_o,
  output logic [FW-1:0] cnt_hour_o,
  output logic [FW-1:0] cnt_min_o,
  output logic [FW-1:0] cnt_sec_o,
  output logic          sec_pulse_o,
  output logic          load_pend_o
);
  logic  load_q;
  logic  adv;
  tvec_t cnt, nxt, bufv;

  always_ff @(posedge clk) begin
    if (rst) load_q <= 1'b0;
    else     load_q <= load_set_i;
  end

  cal_tk_core #(
    .SEC_MAX(SEC_MAX), .MIN_MAX(MIN_MAX), .HOUR_MAX(HOUR_MAX),
    .MON_MAX(MON_MAX), .LEAP_BITS(LEAP_BITS)
  ) u_core (
    .clk     (clk),
    .rst     (rst),
    .tick_i  (tick_i),
    .stop_i  (stop_i),
    .load_i  (load_q),
    .src_i   (bufv),
    .cnt_o   (cnt),
    .nxt_o   (nxt),
    .adv_o   (adv),
    .pulse_o (sec_pulse_o)
  );

  cal_tk_shadow #(.SEC_POR(fld_t'(SEC_POR))) u_shadow (
    .clk     (clk),
    .rst     (rst),
    .copy_i  (adv && !upd_dis_i),
    .src_i   (nxt),
    .we_i    (buf_we_i),
    .sel_i   (buf_sel_i),
    .wdata_i (buf_wdata_i),
    .buf_o   (bufv)
  );

  assign load_pend_o = load_q;
  assign buf_year_o  = bufv[I_YEAR];
  assign buf_month_o = bufv[I_MON];
  assign buf_day_o   = bufv[I_DAY];
  assign buf_hour_o  = bufv[I_HOUR];
  assign buf_min_o   = bufv[I_MIN];
  assign buf_sec_o   = bufv[I_SEC];
  assign cnt_year_o  = cnt[I_YEAR];
  assign cnt_month_o = cnt[I_MON];
  assign cnt_day_o   = cnt[I_DAY];
  assign cnt_hour_o  = cnt[I_HOUR];
  assign cnt_min_o   = cnt[I_MIN];
  assign cnt_sec_o   = cnt[I_SEC];
endmodule

// File: rtl/cal_timekeeper_chk.sv
`timescale 1ns/1ps
module cal_timekeeper_chk #(
  parameter int unsigned SEC_MAX = 59
) (
  input logic       clk,
  input logic       rst,
  input logic       tick_i,
  input logic       stop_i,
  input logic       upd_dis_i,
  input logic       load_set_i,
  input logic       buf_we_i,
  input logic [7:0] buf_year_o,
  input logic [7:0] buf_month_o,
  input logic [7:0] buf_day_o,
  input logic [7:0] buf_hour_o,
  input logic [7:0] buf_min_o,
  input logic [7:0] buf_sec_o,
  input logic [7:0] cnt_year_o,
  input logic [7:0] cnt_month_o,
  input logic [7:0] cnt_day_o,
  input logic [7:0] cnt_hour_o,
  input logic [7:0] cnt_min_o,
  input logic [7:0] cnt_sec_o,
  input logic       sec_pulse_o,
  input logic       load_pend_o
);
  logic [47:0] cv, bv;
  assign cv = {cnt_year_o, cnt_month_o, cnt_day_o, cnt_hour_o, cnt_min_o, cnt_sec_o};
  assign bv = {buf_year_o, buf_month_o, buf_day_o, buf_hour_o, buf_min_o, buf_sec_o};

  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (rst)
    stop_i && !load_pend_o |=> $stable(cv) && !sec_pulse_o); // R4
  AST_BUF_HOLD: assert property (@(posedge clk) disable iff (rst)
    (upd_dis_i || stop_i) && !buf_we_i |=> $stable(bv)); // R5
  AST_COPY_MATCH: assert property (@(posedge clk) disable iff (rst)
    tick_i && !stop_i && !load_pend_o && !upd_dis_i && !buf_we_i |=> bv == cv); // R6
  AST_SEC_RANGE: assert property (@(posedge clk) disable iff (rst)
    sec_pulse_o |-> cnt_sec_o <= 8'(SEC_MAX)); // R2
  AST_LOAD_COPY: assert property (@(posedge clk) disable iff (rst)
    load_pend_o |=> cv == $past(bv)); // R8
  AST_LOAD_ONESHOT: assert property (@(posedge clk) disable iff (rst)
    load_pend_o && !load_set_i |=> !load_pend_o); // R8
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    load_pend_o && tick_i |=> !sec_pulse_o); // R9
  AST_PULSE_SRC: assert property (@(posedge clk) disable iff (rst)
    sec_pulse_o |-> $past(tick_i && !stop_i && !load_pend_o)); // R10
endmodule

bind cal_timekeeper cal_timekeeper_chk #(.SEC_MAX(SEC_MAX)) u_chk (.*);

// File: tb/cal_timekeeper_bench.sv
`timescale 1ns/1ps
module cal_timekeeper_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_i = 0, stop_i = 0, upd_dis_i = 0, load_set_i = 0, buf_we_i = 0;
  logic [2:0] buf_sel_i = '0;
  logic [7:0] buf_wdata_i = '0;
  logic [7:0] by, bmo, bd, bh, bmi, bs, cy, cmo, cd, ch, cmi, cs;
  logic sec_pulse_o, load_pend_o;

  int n_vec = 0, n_bad = 0;
  int m [6];   // model counters: 0 sec .. 5 year
  int mb [6];  // model buffers
  bit done = 0;

  always #2 clk = ~clk;

  cal_timekeeper u_cal_timekeeper (
    .clk(clk), .rst(rst), .tick_i(tick_i), .stop_i(stop_i), .upd_dis_i(upd_dis_i),
    .load_set_i(load_set_i), .buf_we_i(buf_we_i), .buf_sel_i(buf_sel_i),
    .buf_wdata_i(buf_wdata_i),
    .buf_year_o(by), .buf_month_o(bmo), .buf_day_o(bd), .buf_hour_o(bh),
    .buf_min_o(bmi), .buf_sec_o(bs),
    .cnt_year_o(cy), .cnt_month_o(cmo), .cnt_day_o(cd), .cnt_hour_o(ch),
    .cnt_min_o(cmi), .cnt_sec_o(cs),
    .sec_pulse_o(sec_pulse_o), .load_pend_o(load_pend_o)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, string what, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int cnt_at(int i);
    case (i)
      0: return int'(cs);  1: return int'(cmi); 2: return int'(ch);
      3: return int'(cd);  4: return int'(cmo); default: return int'(cy);
    endcase
  endfunction

  function automatic int buf_at(int i);
    case (i)
      0: return int'(bs);  1: return int'(bmi); 2: return int'(bh);
      3: return int'(bd);  4: return int'(bmo); default: return int'(by);
    endcase
  endfunction

  function automatic int bdim(int y, int mo);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_adv();
    int hi;
    bit c;
    c = 1;
    for (int i = 0; i < 5; i++) begin
      case (i)
        0: hi = 59; 1: hi = 59; 2: hi = 23; 3: hi = bdim(m[5], m[4]); default: hi = 12;
      endcase
      if (c) begin
        if (m[i] >= hi) m[i] = (i >= 3) ? 1 : 0;
        else begin m[i] = m[i] + 1; c = 0; end
      end
    end
    if (c) m[5] = (m[5] + 1) % 256;
  endtask

  task automatic check_all(string req);
    for (int i = 0; i < 6; i++) begin
      chk(req, $sformatf("counter %0d", i), cnt_at(i), m[i]);
      chk(req, $sformatf("buffer %0d", i), buf_at(i), mb[i]);
    end
  endtask

  task automatic do_tick(bit st, bit ud, string req);
    stop_i = st; upd_dis_i = ud; tick_i = 1;
    step();
    tick_i = 0;
    if (!st) begin
      model_adv();
      if (!ud) mb = m;
    end
    chk(req, "sec_pulse", int'(sec_pulse_o), st ? 0 : 1);
    check_all(req);
    step();
    chk("R10", "pulse drop", int'(sec_pulse_o), 0);
    stop_i = 0; upd_dis_i = 0;
  endtask

  task automatic wr_buf(int sel, int val);
    buf_we_i = 1; buf_sel_i = 3'(sel); buf_wdata_i = 8'(val);
    step();
    buf_we_i = 0;
    if (sel < 6) mb[sel] = val;
  endtask

  task automatic do_load(string req);
    load_set_i = 1;
    step();
    load_set_i = 0;
    chk("R8", "load_pend set", int'(load_pend_o), 1);
    step();
    m = mb;
    chk("R8", "load_pend clear", int'(load_pend_o), 0);
    check_all(req);
  endtask

  task automatic set_buffers(int y, int mo, int d, int h, int mi, int s);
    wr_buf(5, y); wr_buf(4, mo); wr_buf(3, d); wr_buf(2, h); wr_buf(1, mi); wr_buf(0, s);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int ys [6] = '{0, 1, 2, 3, 4, 255};
    repeat (3) step();
    rst = 0;
    // R1: reset state
    m  = '{0, 0, 0, 1, 1, 0};
    mb = '{255, 0, 0, 1, 1, 0};
    check_all("R1");
    chk("R1", "sec_pulse", int'(sec_pulse_o), 0);
    chk("R1", "load_pend", int'(load_pend_o), 0);

    // R2, R6, R10: run a little past one hour of ticks
    for (int t = 0; t < 3700; t++) do_tick(0, 0, "R2");

    // R3: end-of-month rollover for every month in several years
    foreach (ys[k]) begin
      for (int mo = 1; mo <= 12; mo++) begin
        set_buffers(ys[k], mo, bdim(ys[k], mo), 23, 59, 59);
        do_load("R8");
        do_tick(0, 0, "R3");
      end
    end

    // R4: stop freezes counters and buffers
    do_tick(1, 0, "R4");
    do_tick(1, 0, "R4");

    // R5: update-disable keeps buffers, counters run
    do_tick(0, 1, "R5");
    do_tick(0, 1, "R5");
    do_tick(0, 0, "R6");

    // R7: unused select codes ignored
    wr_buf(6, 8'h55); check_all("R7");
    wr_buf(7, 8'hAA); check_all("R7");
    // R7: host write beats copy on the written field
    buf_we_i = 1; buf_sel_i = 3'd1; buf_wdata_i = 8'd42; tick_i = 1;
    step();
    buf_we_i = 0; tick_i = 0;
    model_adv(); mb = m; mb[1] = 42;
    check_all("R7");
    step();

    // R9: tick in the load cycle is discarded
    set_buffers(10, 6, 15, 12, 30, 20);
    load_set_i = 1;
    step();
    load_set_i = 0; tick_i = 1;
    step();
    tick_i = 0;
    m = mb;
    chk("R9", "sec_pulse", int'(sec_pulse_o), 0);
    chk("R9", "load_pend", int'(load_pend_o), 0);
    check_all("R9");
    step();

    // R11: out-of-range loaded values wrap on the next step
    set_buffers(7, 13, 40, 30, 70, 255);
    do_load("R11");
    do_tick(0, 0, "R11");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule